// File: doc/BRIEF.md
# External Bus Access Sequencer with Write-to-Read Turnaround

This block runs one memory access at a time for a small system bus. An internal requester presents a request that carries an address, write data, a direction bit and a flag. The flag says whether the target is an off-chip device or on-chip memory. For off-chip targets the block drives active-low chip select, read strobe and write strobe, an address bus, and write data with an output enable. It captures read data from the pins at the end of the read strobe. On-chip accesses finish after a fixed internal latency and leave every external pin idle.

Three kinds of wait can stretch the external timing. A programmed wait count holds the active strobe low for extra cycles. A float count holds off the next external access after a read, so the device has time to release the data lines. A single turnaround cycle is added when the most recent external access was a write and the new external access is a read. An on-chip access between them cancels that turnaround. These waits add together and never replace one another. A one-cycle completion pulse marks the end of every access. New requests are taken only while the block reports itself ready.

Top module: `ebus_turn_ctrl`

## Requirements
- R1: While reset is low and right after it is released, chip select, read strobe and write strobe are high (inactive), data output enable and done are low, and ready is high.
- R2: An external read drives chip select and read strobe low together for 1 + cfg_wait cycles. In the cycle after the strobe ends, done is high and rd_data holds the ext_din value sampled in the last strobe cycle.
- R3: An external write drives write strobe low for 1 + cfg_wait cycles, with ext_addr, ext_dout and ext_doe valid for the whole strobe. This is followed by exactly one hold cycle with chip select still low, write strobe high and data still driven. Done is high in the cycle after the hold cycle.
- R4: When the last completed access was an external write, an accepted external read first spends exactly one cycle with chip select and both strobes high, and then starts its read strobe. This holds whatever the idle time since the write. The programmed wait still applies in full to the strobe that follows.
- R5: With cfg_float = 0, a read strobe starts in the cycle right after acceptance for read after read. A write strobe does the same for write after write and for write after read.
- R6: An on-chip access raises done exactly two cycles after acceptance, leaves chip select low in none of those cycles, and clears the turnaround memory. A later external read therefore gets no turnaround cycle.
- R7: After an external read completes, the block counts cfg_float cycles, starting in the cycle where done is high. An external access accepted before that count has run out is held with chip select high until it has.
- R8: The float count never delays an on-chip access, and it keeps running while one is in progress.
- R9: Ready is high only while the block is idle. A request raised while ready is low is dropped and causes no access.
- R10: Done is a single-cycle pulse, issued once for each completed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ext | input | 1 | 1 = off-chip target, 0 = on-chip memory |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| cfg_wait | input | WAIT_W | Extra strobe cycles per external access |
| cfg_float | input | FLOAT_W | Hold-off cycles after an external read |
| req_ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle pulse when an access completes |
| rd_data | output | DATA_W | Data captured by the last external read |
| ext_cs_n | output | 1 | Chip select, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_addr | output | ADDR_W | External address |
| ext_dout | output | DATA_W | External write data |
| ext_doe | output | 1 | Write data output enable |
| ext_din | input | DATA_W | External read data |

## Verification
The bench targets the orderings where a turnaround cycle is easy to get wrong. A design that keys the turnaround on access type alone would stall read after read or write after read. One that ignores the direction of the previous access would miss write after read. One that forgets an on-chip access in between would stall the read after it. One that lets the memory decay during idle time would skip the turnaround after a long gap. The float count is tested both as a stall between external accesses and as a count that must keep running through an on-chip access. An off-by-one in its loading would show up as a read strobe one cycle early or late. Write data hold is checked in the cycle after the write strobe rises, which catches a design that drops the data or chip select together with the strobe. A request raised while the block is busy is checked for being dropped rather than queued.

// File: rtl/ebt_pkg.sv
// Shared types for the external bus turnaround sequencer.
package ebt_pkg;
    // Sequencer states; one access is in flight at a time.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // waiting for a request
        ST_INT   = 3'd1,   // on-chip access, one cycle
        ST_TURN  = 3'd2,   // write-to-read turnaround cycle
        ST_FLOAT = 3'd3,   // waiting for the float count to expire
        ST_STRB  = 3'd4,   // strobe low, programmed waits counted here
        ST_HOLD  = 3'd5    // write data hold after the strobe rises
    } ebt_state_t;
endpackage

// File: rtl/ebt_down_cnt.sv
// Loadable down counter that stops at zero.
// Assumes: load takes priority over decrement; decrement at zero has no effect.
module ebt_down_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    // Load, or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/ebt_req_reg.sv
// Holds the accepted request for the length of the external access.
// Assumes: capture is pulsed only when the sequencer accepts a request.
module ebt_req_reg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              q_write,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_data
);
    // Register the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_addr  <= '0;
            q_data  <= '0;
        end else if (capture) begin
            q_write <= in_write;
            q_addr  <= in_addr;
            q_data  <= in_data;
        end
    end
endmodule

// File: rtl/ebus_turn_ctrl.sv
// External bus access sequencer with write-to-read turnaround.
// Runs one access at a time. External accesses drive the chip select and
// the strobes. Programmed waits stretch the strobe, a float count after
// reads holds off the next external access, and one turnaround cycle
// separates an external write from a following external read. On-chip
// accesses finish in one cycle and leave the pins idle.
// Assumes: cfg inputs are stable while an access is in flight.
module ebus_turn_ctrl
    import ebt_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int WAIT_W  = 3,
    parameter int FLOAT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_ext,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic [FLOAT_W-1:0] cfg_float,
    output logic               req_ready,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output logic               ext_cs_n,
    output logic               ext_rd_n,
    output logic               ext_wr_n,
    output logic [ADDR_W-1:0]  ext_addr,
    output logic [DATA_W-1:0]  ext_dout,
    output logic               ext_doe,
    input  logic [DATA_W-1:0]  ext_din
);
    ebt_state_t          state, state_nx;
    logic                accept;
    logic                cur_write;
    logic                last_ext_wr;
    logic                finish_rd;
    logic                wait_zero;
    logic                float_busy;
    logic [WAIT_W-1:0]   wait_cnt;
    logic [FLOAT_W-1:0]  float_cnt;

    assign accept     = (state == ST_IDLE) && req_valid;
    assign wait_zero  = (wait_cnt == '0);
    assign float_busy = (float_cnt != '0);
    assign finish_rd  = (state == ST_STRB) && wait_zero && !cur_write;

    ebt_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (accept),
        .in_write (req_write),
        .in_addr  (req_addr),
        .in_data  (req_wdata),
        .q_write  (cur_write),
        .q_addr   (ext_addr),
        .q_data   (ext_dout)
    );

    // Programmed wait counter: loaded on accept, counted during the strobe.
    ebt_down_cnt #(.W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cfg_wait),
        .dec      (state == ST_STRB),
        .cnt      (wait_cnt)
    );

    // Float counter: loaded at read completion, free-running down to zero.
    ebt_down_cnt #(.W(FLOAT_W)) u_float (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (finish_rd),
        .load_val (cfg_float),
        .dec      (1'b1),
        .cnt      (float_cnt)
    );

    // Next-state selection for the access sequence.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_ext)
                        state_nx = ST_INT;
                    else if (!req_write && last_ext_wr)
                        state_nx = ST_TURN;
                    else if (float_busy)
                        state_nx = ST_FLOAT;
                    else
                        state_nx = ST_STRB;
                end
            end
            ST_INT:   state_nx = ST_IDLE;
            ST_TURN:  state_nx = float_busy ? ST_FLOAT : ST_STRB;
            ST_FLOAT: if (!float_busy) state_nx = ST_STRB;
            ST_STRB:  if (wait_zero) state_nx = cur_write ? ST_HOLD : ST_IDLE;
            ST_HOLD:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Completion pulse, turnaround memory and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            last_ext_wr <= 1'b0;
            rd_data     <= '0;
        end else begin
            done <= (state == ST_INT) || (state == ST_HOLD) || finish_rd;
            if (state == ST_HOLD)
                last_ext_wr <= 1'b1;
            else if (state == ST_INT || finish_rd)
                last_ext_wr <= 1'b0;
            if (finish_rd)
                rd_data <= ext_din;
        end
    end

    // Pin decode from the current state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        ext_cs_n  = !((state == ST_STRB) || (state == ST_HOLD));
        ext_rd_n  = !((state == ST_STRB) && !cur_write);
        ext_wr_n  = !((state == ST_STRB) && cur_write);
        ext_doe   = ((state == ST_STRB) || (state == ST_HOLD)) && cur_write;
    end
endmodule

// File: rtl/ebus_turn_checker.sv
// Protocol checks on the external pins and the handshake of ebus_turn_ctrl.
// Assumes: attached by bind; observes ports only.
module ebus_turn_checker (
    input logic clk,
    input logic rst_n,
    input logic ext_cs_n,
    input logic ext_rd_n,
    input logic ext_wr_n,
    input logic ext_doe,
    input logic done,
    input logic req_ready
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n)); // R2
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> !ext_cs_n); // R3
    AST_WDATA_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr_n |-> ext_doe); // R3
    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_wr_n) |-> (ext_doe && !ext_cs_n)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_cs_n |-> !req_ready); // R9
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R9
endmodule

bind ebus_turn_ctrl ebus_turn_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_cs_n  (ext_cs_n),
    .ext_rd_n  (ext_rd_n),
    .ext_wr_n  (ext_wr_n),
    .ext_doe   (ext_doe),
    .done      (done),
    .req_ready (req_ready)
);

// File: tb/ebus_turn_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench for ebus_turn_ctrl: one task per scenario.
module ebus_turn_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_ext = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [2:0]  cfg_wait = '0;
    logic [2:0]  cfg_float = '0;
    logic        req_ready, done, ext_cs_n, ext_rd_n, ext_wr_n, ext_doe;
    logic [15:0] rd_data, ext_addr, ext_dout, ext_din;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    // External device model: read data is a fixed function of the address.
    assign ext_din = ext_addr ^ 16'h5A5A;

    ebus_turn_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_ext(req_ext), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_wait(cfg_wait), .cfg_float(cfg_float), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_addr(ext_addr), .ext_dout(ext_dout),
        .ext_doe(ext_doe), .ext_din(ext_din)
    );

    function automatic void chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endfunction

    // Runs one access starting at a negedge with the block idle; returns at
    // the negedge where done is seen. exp_lead < 0 skips the lead check.
    task automatic run_access(bit wr, bit ext, logic [15:0] a, logic [15:0] d,
                              int exp_lead, string req, bit poke = 1'b0);
        int  lead = 0, strb = 0, n = 0, touched = 0;
        bit  seen = 1'b0, prev_wr_low = 1'b0;
        chk(req_ready == 1'b1, req, "ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_ext = ext; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            n++;
            if (poke && n == 1) begin
                chk(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
                req_valid = 1'b1; req_write = 1'b1; req_ext = 1'b1; req_addr = 16'hDEAD;
            end else if (poke && n == 2) begin
                req_valid = 1'b0;
            end
            if (!ext_cs_n) touched++;
            if (!ext_rd_n || !ext_wr_n) begin
                seen = 1'b1;
                strb++;
                if (!ext_wr_n && (!ext_doe || ext_dout != d || ext_addr != a))
                    chk(1'b0, req, "write data during strobe", ext_dout, d);
            end else if (!seen && ext_cs_n) begin
                lead++;
            end
            if (prev_wr_low && ext_wr_n)
                chk(!ext_cs_n && ext_doe && ext_dout == d, "R3", "hold cycle cs/doe/data",
                    {ext_cs_n, ext_doe}, 1);
            prev_wr_low = !ext_wr_n;
            if (done || n > 60) break;
            @(negedge clk);
        end
        chk(done == 1'b1, req, "done seen", done, 1);
        if (!ext) begin
            chk(n == 2, "R6", "on-chip done latency", n, 2);
            chk(touched == 0, "R6", "on-chip cs cycles", touched, 0);
        end else begin
            if (exp_lead >= 0) chk(lead == exp_lead, req, "cycles before strobe", lead, exp_lead);
            chk(strb == 1 + int'(cfg_wait), req, "strobe width", strb, 1 + int'(cfg_wait));
            if (wr)
                chk(n == lead + strb + 2, "R3", "write done timing", n, lead + strb + 2);
            else begin
                chk(n == lead + strb + 1, "R2", "read done timing", n, lead + strb + 1);
                chk(rd_data == (a ^ 16'h5A5A), "R2", "read data", rd_data, a ^ 16'h5A5A);
            end
        end
    endtask

    task automatic idle(int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(ext_cs_n && ext_rd_n && ext_wr_n && !ext_doe && !done, "R1", "pins in reset",
            {ext_cs_n, ext_rd_n, ext_wr_n, ext_doe, done}, 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ext_cs_n && ext_rd_n && ext_wr_n && !ext_doe && !done && req_ready, "R1",
            "pins after reset", {ext_cs_n, ext_rd_n, ext_wr_n, ext_doe, done, req_ready}, 6'b111001);
    endtask

    task automatic t_basic();
        cfg_wait = 3'd0; run_access(1'b0, 1'b1, 16'h0010, 16'h0, 0, "R2");
        cfg_wait = 3'd3; run_access(1'b0, 1'b1, 16'h0123, 16'h0, 0, "R2");
        idle(2);
        cfg_wait = 3'd0; run_access(1'b1, 1'b1, 16'h0200, 16'hA1B2, 0, "R3");
        cfg_wait = 3'd2; run_access(1'b1, 1'b1, 16'h0204, 16'hC3D4, 0, "R3");
        idle(2);
    endtask

    task automatic t_turnaround();
        cfg_wait = 3'd0; run_access(1'b1, 1'b1, 16'h0300, 16'h1111, 0, "R3");
        cfg_wait = 3'd2; run_access(1'b0, 1'b1, 16'h0304, 16'h0, 1, "R4");
        cfg_wait = 3'd0; run_access(1'b1, 1'b1, 16'h0308, 16'h2222, 0, "R5");
        idle(5);
        run_access(1'b0, 1'b1, 16'h030C, 16'h0, 1, "R4");
        idle(2);
    endtask

    task automatic t_no_turn();
        cfg_wait = 3'd1;
        run_access(1'b0, 1'b1, 16'h0400, 16'h0, 0, "R5");
        run_access(1'b0, 1'b1, 16'h0402, 16'h0, 0, "R5");
        run_access(1'b1, 1'b1, 16'h0404, 16'h3333, 0, "R5");
        run_access(1'b1, 1'b1, 16'h0406, 16'h4444, 0, "R5");
        idle(2);
    endtask

    task automatic t_internal();
        cfg_wait = 3'd0;
        run_access(1'b1, 1'b1, 16'h0500, 16'h5555, 0, "R3");
        run_access(1'b0, 1'b0, 16'h0000, 16'h0, -1, "R6");
        run_access(1'b0, 1'b1, 16'h0504, 16'h0, 0, "R6");
        idle(2);
    endtask

    task automatic t_float();
        cfg_wait = 3'd0; cfg_float = 3'd3;
        run_access(1'b0, 1'b1, 16'h0600, 16'h0, 0, "R7");
        run_access(1'b0, 1'b1, 16'h0602, 16'h0, 3, "R7");
        run_access(1'b0, 1'b0, 16'h0000, 16'h0, -1, "R8");
        run_access(1'b0, 1'b1, 16'h0604, 16'h0, 1, "R8");
        run_access(1'b1, 1'b1, 16'h0606, 16'h6666, 3, "R7");
        cfg_float = 3'd0;
        idle(4);
    endtask

    task automatic t_busy_ignore();
        cfg_wait = 3'd2;
        run_access(1'b0, 1'b1, 16'h0700, 16'h0, 1, "R9", 1'b1);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done lasts one cycle", done, 0);
        for (int i = 0; i < 4; i++) begin
            chk(ext_cs_n && req_ready && !done, "R9", "dropped request made no access",
                {ext_cs_n, req_ready, done}, 3'b110);
            @(negedge clk);
        end
    endtask

    initial begin
        t_reset();
        t_basic();
        t_turnaround();
        t_no_turn();
        t_internal();
        t_float();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule